// File: doc/BRIEF.md
# Valley-Switched Boost Gate Sequencer

This block produces the power-switch gate pulse for a boost power-factor-correction stage running in discontinuous conduction with a variable period. Each conduction cycle starts with a turn-on edge. It ends when a requested on-time has run out, or earlier when the current-sense comparator trips outside a leading-edge blanking window. After turn-off the block ignores the demagnetization comparator for a blanking interval. It then starts the next cycle when the auxiliary winding is reported below zero, so the switch turns on in the valley of the ring.

The block enforces a lower bound on the switching period. The bound depends on the rectified-line sample: it is shortest at the line crest and longer toward the zero crossing. Its shortest value is the frequency ceiling of the chosen variant. Because the on-time is fixed for a pulse while the period follows the line, both the duty cycle and the period move with the line. A watchdog forces a restart if no valley arrives after turn-off. A standby input holds the gate low. All inputs are sampled levels with no handshake: the line sample and the on-time word are plain status words that the block reads at each turn-on, so they never apply back-pressure.

Top module: `vsb_gate_seq`

## Requirements
- R1: While reset is held, and after reset until a start condition occurs, `gate_o` and `cycle_done_o` are low.
- R2: With `standby_i` high at a clock edge, `gate_o` is low after that edge, no cycle starts, an aborted pulse gives no `cycle_done_o`, and the off-time count restarts.
- R3: Outside the watchdog case, a turn-on happens only at an edge where `zcd_below_i` is high.
- R4: `zcd_below_i` is ignored until the gate has been low for ZCB_CYC+1 cycles. With the valley always present and the period bound met, the period is the on-time plus ZCB_CYC+1.
- R5: The rise-to-rise distance of `gate_o` is never below the ceiling period: PER_BASE cycles when HIGH_FREQ is 0, PER_HIGH cycles when HIGH_FREQ is 1.
- R6: The minimum period taken at each turn-on is ceiling + (((2^LW-1) - line_i) * SPAN_CYC) >> LW, using the `line_i` sampled at that turn-on edge. A full-scale line sample gives the highest rate.
- R7: A pulse that is not cut short lasts exactly N cycles. N is `ton_i` sampled at the turn-on edge, and a value of 0 counts as 1. Changes to `ton_i` during the pulse have no effect.
- R8: `cs_trip_i` is ignored during the first LEB_CYC cycles of a pulse.
- R9: If `cs_trip_i` is high in pulse cycle k > LEB_CYC, the gate is low from the next cycle. The pulse therefore lasts LEB_CYC+1 cycles when the trip is held.
- R10: If the gate has been low for WDOG_CYC+1 cycles without a valley start, a turn-on is forced once the period bound is met.
- R11: `cycle_done_o` is high for exactly the first low cycle after every pulse that ends by timeout or by current limit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| standby_i | input | 1 | Holds the gate low and blocks new cycles |
| zcd_below_i | input | 1 | Auxiliary winding below zero (valley comparator) |
| cs_trip_i | input | 1 | Switch current above limit (current-sense comparator) |
| line_i | input | LW | Rectified-line sample, full scale at crest |
| ton_i | input | TW | Requested on-time in clock cycles |
| gate_o | output | 1 | Gate drive command |
| cycle_done_o | output | 1 | One-cycle strobe at the end of a conduction pulse |

## Verification
The assertions assume that every input is synchronous to `clk` and is read only at rising edges. They also assume the parameters are static and consistent: WDOG_CYC is at least ZCB_CYC, and the ceiling period plus SPAN_CYC fits in the CW-bit counters, so the saturated period count always satisfies the bound. The stimulus changes inputs only just after falling edges and only uses parameter sets that meet these relations. It drives a base and a high-frequency instance side by side with the same comparator and line patterns. Standby is raised only in the middle of a pulse, so the abort path and the blocked-start path are both visited.

// File: rtl/vsb_pkg.sv
package vsb_pkg;
  typedef enum logic {
    PH_OFF = 1'b0,
    PH_ON  = 1'b1
  } phase_t;
endpackage

// File: rtl/vsb_sat_counter.sv
module vsb_sat_counter #(
  parameter int unsigned W        = 16,
  parameter bit          RST_FULL = 1'b0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clr_i,
  input  logic         en_i,
  output logic [W-1:0] cnt_o
);
  localparam logic [W-1:0] TOP = '1;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_o <= RST_FULL ? TOP : '0;
    end else if (clr_i) begin
      cnt_o <= '0;
    end else if (en_i && cnt_o != TOP) begin
      cnt_o <= cnt_o + 1'b1;
    end
  end
endmodule

// File: rtl/vsb_period_shaper.sv
module vsb_period_shaper #(
  parameter bit          HIGH_FREQ = 1'b0,
  parameter int unsigned CW        = 16,
  parameter int unsigned LW        = 10,
  parameter int unsigned PER_BASE  = 3572,
  parameter int unsigned PER_HIGH  = 2500,
  parameter int unsigned SPAN_CYC  = 2048
) (
  input  logic [LW-1:0] line_i,
  output logic [CW-1:0] min_per_o
);
  localparam int unsigned PW = LW + CW;

  logic [CW-1:0] ceil_per;
  logic [LW-1:0] depth;
  logic [PW-1:0] stretch;

  // variant picks the shortest permitted period
  generate
    if (HIGH_FREQ) begin : g_fast
      assign ceil_per = CW'(PER_HIGH);
    end else begin : g_base
      assign ceil_per = CW'(PER_BASE);
    end
  endgenerate

  // distance of the sample below full scale (crest)
  assign depth     = ~line_i;
  assign stretch   = PW'(depth) * PW'(SPAN_CYC);
  assign min_per_o = ceil_per + CW'(stretch >> LW);
endmodule

// File: rtl/vsb_gate_seq.sv
module vsb_gate_seq
  import vsb_pkg::*;
#(
  parameter bit          HIGH_FREQ = 1'b0,
  parameter int unsigned CW        = 16,
  parameter int unsigned TW        = 12,
  parameter int unsigned LW        = 10,
  parameter int unsigned LEB_CYC   = 50,
  parameter int unsigned ZCB_CYC   = 100,
  parameter int unsigned WDOG_CYC  = 12500,
  parameter int unsigned PER_BASE  = 3572,
  parameter int unsigned PER_HIGH  = 2500,
  parameter int unsigned SPAN_CYC  = 2048
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          standby_i,
  input  logic          zcd_below_i,
  input  logic          cs_trip_i,
  input  logic [LW-1:0] line_i,
  input  logic [TW-1:0] ton_i,
  output logic          gate_o,
  output logic          cycle_done_o
);
  localparam logic [CW-1:0] LEB_L  = CW'(LEB_CYC);
  localparam logic [CW-1:0] ZCB_L  = CW'(ZCB_CYC);
  localparam logic [CW-1:0] WDOG_L = CW'(WDOG_CYC);

  phase_t        state_q;
  logic [TW-1:0] ton_q;
  logic [CW-1:0] minper_q;
  logic [CW-1:0] minper_c;
  logic [CW-1:0] on_cnt;
  logic [CW-1:0] off_cnt;
  logic [CW-1:0] per_cnt;
  logic          done_q;
  logic          start_c;
  logic          end_c;
  logic          valley_c;
  logic          wdog_c;
  logic          period_ok_c;
  logic          len_c;
  logic          lim_c;
  logic          is_on;
  logic          is_off;

  assign is_on  = (state_q == PH_ON);
  assign is_off = (state_q == PH_OFF);

  vsb_period_shaper #(
    .HIGH_FREQ(HIGH_FREQ), .CW(CW), .LW(LW),
    .PER_BASE(PER_BASE), .PER_HIGH(PER_HIGH), .SPAN_CYC(SPAN_CYC)
  ) u_shaper (
    .line_i   (line_i),
    .min_per_o(minper_c)
  );

  // cycles since turn-on
  vsb_sat_counter #(.W(CW), .RST_FULL(1'b0)) u_on_cnt (
    .clk(clk), .rst_n(rst_n), .clr_i(start_c), .en_i(is_on), .cnt_o(on_cnt)
  );

  // cycles since turn-off (restarted by standby)
  vsb_sat_counter #(.W(CW), .RST_FULL(1'b0)) u_off_cnt (
    .clk(clk), .rst_n(rst_n), .clr_i(end_c || standby_i), .en_i(is_off), .cnt_o(off_cnt)
  );

  // cycles since the previous turn-on; saturated out of reset
  vsb_sat_counter #(.W(CW), .RST_FULL(1'b1)) u_per_cnt (
    .clk(clk), .rst_n(rst_n), .clr_i(start_c), .en_i(1'b1), .cnt_o(per_cnt)
  );

  always_comb begin
    period_ok_c = per_cnt >= (minper_q - 1'b1);
    valley_c    = zcd_below_i && (off_cnt >= ZCB_L);
    wdog_c      = off_cnt >= WDOG_L;
    start_c     = is_off && !standby_i && period_ok_c && (valley_c || wdog_c);
    len_c       = on_cnt >= CW'(ton_q - 1'b1);
    lim_c       = cs_trip_i && (on_cnt >= LEB_L);
    end_c       = is_on && !standby_i && (len_c || lim_c);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q  <= PH_OFF;
      ton_q    <= TW'(1);
      minper_q <= CW'(1);
      done_q   <= 1'b0;
    end else begin
      done_q <= end_c;
      if (standby_i || end_c) begin
        state_q <= PH_OFF;
      end else if (start_c) begin
        state_q  <= PH_ON;
        ton_q    <= (ton_i == '0) ? TW'(1) : ton_i;
        minper_q <= minper_c;
      end
    end
  end

  assign gate_o       = is_on;
  assign cycle_done_o = done_q;
endmodule

// File: rtl/vsb_gate_seq_chk.sv
module vsb_gate_seq_chk #(
  parameter bit          HIGH_FREQ = 1'b0,
  parameter int unsigned CW        = 16,
  parameter int unsigned TW        = 12,
  parameter int unsigned LEB_CYC   = 50,
  parameter int unsigned ZCB_CYC   = 100,
  parameter int unsigned WDOG_CYC  = 12500,
  parameter int unsigned PER_BASE  = 3572,
  parameter int unsigned PER_HIGH  = 2500,
  parameter int unsigned SPAN_CYC  = 2048
) (
  input logic          clk,
  input logic          rst_n,
  input logic          standby_i,
  input logic          zcd_below_i,
  input logic          cs_trip_i,
  input logic [TW-1:0] ton_i,
  input logic          gate_o,
  input logic          cycle_done_o
);
  localparam int unsigned   CEIL   = HIGH_FREQ ? PER_HIGH : PER_BASE;
  localparam logic [CW-1:0] CEIL_L = CW'(CEIL);
  localparam logic [CW-1:0] MAXP_L = CW'(CEIL + SPAN_CYC);
  localparam logic [CW-1:0] LEB_L  = CW'(LEB_CYC);
  localparam logic [CW-1:0] ZCB_L  = CW'(ZCB_CYC);
  localparam logic [CW-1:0] WDOG_L = CW'(WDOG_CYC);
  localparam logic [CW-1:0] TOP    = '1;

  logic          gate_d;
  logic [CW-1:0] hi_c;
  logic [CW-1:0] lo_c;
  logic [CW-1:0] gap_c;
  logic [TW-1:0] tprev;
  logic [TW-1:0] tlat;
  logic [TW-1:0] ton_cur;
  logic          first_hi;
  logic          at_len;

  assign first_hi = gate_o && !gate_d;
  assign ton_cur  = first_hi ? ((tprev == '0) ? TW'(1) : tprev) : tlat;
  assign at_len   = (32'(hi_c) + 32'd1) >= 32'(ton_cur);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      gate_d <= 1'b0;
      hi_c   <= '0;
      lo_c   <= '0;
      gap_c  <= TOP;
      tprev  <= '0;
      tlat   <= TW'(1);
    end else begin
      gate_d <= gate_o;
      tprev  <= ton_i;
      if (first_hi) tlat <= ton_cur;
      hi_c <= gate_o ? ((hi_c == TOP) ? hi_c : hi_c + 1'b1) : '0;
      if (gate_o || standby_i) lo_c <= '0;
      else if (lo_c != TOP)    lo_c <= lo_c + 1'b1;
      if (first_hi)            gap_c <= CW'(1);
      else if (gap_c != TOP)   gap_c <= gap_c + 1'b1;
    end
  end

  assert_standby_blocks_R2: assert property (@(posedge clk) disable iff (!rst_n)
    standby_i |=> !gate_o);

  // covers the blanking of R4 as well
  assert_valley_start_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(gate_o) |-> (($past(zcd_below_i) && $past(lo_c) >= ZCB_L) || $past(lo_c) >= WDOG_L));

  assert_freq_ceiling_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(gate_o) |-> gap_c >= CEIL_L);

  assert_ontime_end_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (gate_o && at_len) |=> !gate_o);

  assert_leb_mask_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (gate_o && !standby_i && hi_c < LEB_L && !at_len) |=> gate_o);

  assert_cs_cut_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (gate_o && !standby_i && cs_trip_i && hi_c >= LEB_L) |=> (!gate_o && cycle_done_o));

  assert_watchdog_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (!gate_o && !standby_i && lo_c >= WDOG_L && gap_c >= MAXP_L) |=> gate_o);

  assert_done_after_pulse_R11: assert property (@(posedge clk) disable iff (!rst_n)
    cycle_done_o |-> (!gate_o && $past(gate_o)));

  assert_done_on_fall_R11: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(gate_o) && !$past(standby_i)) |-> cycle_done_o);
endmodule

bind vsb_gate_seq vsb_gate_seq_chk #(
  .HIGH_FREQ(HIGH_FREQ), .CW(CW), .TW(TW), .LEB_CYC(LEB_CYC), .ZCB_CYC(ZCB_CYC),
  .WDOG_CYC(WDOG_CYC), .PER_BASE(PER_BASE), .PER_HIGH(PER_HIGH), .SPAN_CYC(SPAN_CYC)
) u_chk (
  .clk(clk), .rst_n(rst_n), .standby_i(standby_i), .zcd_below_i(zcd_below_i),
  .cs_trip_i(cs_trip_i), .ton_i(ton_i), .gate_o(gate_o), .cycle_done_o(cycle_done_o)
);

// File: tb/test_vsb_gate_seq.sv
module test_vsb_gate_seq;
  localparam int CW = 12, TW = 8, LW = 6;
  localparam int LEB = 4, ZCB = 6, WDOG = 80;
  localparam int PB = 40, PH = 28, SPAN = 32;
  localparam int LMAX = (1 << LW) - 1;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2 clk = ~clk;

  logic          stby = 1'b0, zcd = 1'b0, cs = 1'b0;
  logic [LW-1:0] line = '1;
  logic [TW-1:0] ton = 8'd10;
  logic          g0, g1, d0, d1;

  vsb_gate_seq #(.HIGH_FREQ(1'b0), .CW(CW), .TW(TW), .LW(LW), .LEB_CYC(LEB), .ZCB_CYC(ZCB),
    .WDOG_CYC(WDOG), .PER_BASE(PB), .PER_HIGH(PH), .SPAN_CYC(SPAN)) i_vsb_gate_seq (
    .clk(clk), .rst_n(rst_n), .standby_i(stby), .zcd_below_i(zcd), .cs_trip_i(cs),
    .line_i(line), .ton_i(ton), .gate_o(g0), .cycle_done_o(d0));

  vsb_gate_seq #(.HIGH_FREQ(1'b1), .CW(CW), .TW(TW), .LW(LW), .LEB_CYC(LEB), .ZCB_CYC(ZCB),
    .WDOG_CYC(WDOG), .PER_BASE(PB), .PER_HIGH(PH), .SPAN_CYC(SPAN)) i_vsb_gate_seq_hf (
    .clk(clk), .rst_n(rst_n), .standby_i(stby), .zcd_below_i(zcd), .cs_trip_i(cs),
    .line_i(line), .ton_i(ton), .gate_o(g1), .cycle_done_o(d1));

  int    total = 0, bad = 0;
  string phase = "R1";
  bit    finished = 1'b0;

  task automatic chk(string req, int act, int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // behavioural reference, one slot per variant
  int m_on[2], m_off[2], m_per[2], m_ton[2], m_minp[2];
  bit m_g[2], m_d[2];

  always @(posedge clk) begin
    for (int v = 0; v < 2; v++) begin
      if (!rst_n) begin
        m_g[v] = 0; m_d[v] = 0; m_on[v] = 0; m_off[v] = 0;
        m_per[v] = 1 << 20; m_ton[v] = 1; m_minp[v] = 1;
      end else begin
        m_d[v] = 0;
        if (stby) begin
          m_g[v] = 0; m_off[v] = 0; m_per[v]++;
        end else if (m_g[v]) begin
          if (m_on[v] >= m_ton[v] - 1 || (cs && m_on[v] >= LEB)) begin
            m_g[v] = 0; m_d[v] = 1; m_off[v] = 0;
          end else begin
            m_on[v]++;
          end
          m_per[v]++;
        end else if (m_per[v] >= m_minp[v] - 1 &&
                     ((zcd && m_off[v] >= ZCB) || m_off[v] >= WDOG)) begin
          m_g[v] = 1; m_on[v] = 0; m_per[v] = 0;
          m_ton[v] = (ton == 0) ? 1 : int'(ton);
          m_minp[v] = (v ? PH : PB) + (((LMAX - int'(line)) * SPAN) >> LW);
        end else begin
          m_off[v]++; m_per[v]++;
        end
      end
    end
  end

  // per-cycle comparison and pulse measurement
  int cyc = 0;
  bit prev_g[2];
  int rise_at[2], last_int[2], hi_run[2], hi_len[2];

  always @(negedge clk) begin
    cyc++;
    if (rst_n) begin
      chk({phase, " gate base"}, g0, m_g[0]);
      chk({phase, " gate high"}, g1, m_g[1]);
      chk({phase, " done base"}, d0, m_d[0]);
      chk({phase, " done high"}, d1, m_d[1]);
    end
    for (int v = 0; v < 2; v++) begin
      bit gv;
      gv = v ? g1 : g0;
      if (gv && !prev_g[v]) begin
        last_int[v] = cyc - rise_at[v];
        rise_at[v] = cyc;
      end
      if (gv) hi_run[v]++;
      else if (prev_g[v]) begin
        hi_len[v] = hi_run[v];
        hi_run[v] = 0;
      end
      prev_g[v] = gv;
    end
  end

  task automatic run(int n);
    repeat (n) @(negedge clk);
    #1;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      total++; bad++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    bit seen;
    run(5);
    chk("R1 gate in reset", g0, 0);
    chk("R1 gate in reset hf", g1, 0);
    chk("R1 done in reset", d0, 0);
    rst_n = 1'b1;
    run(2);
    chk("R1 gate after reset", g0, 0);

    phase = "R3";
    run(40);
    chk("R3 no valley base", g0, 0);
    chk("R3 no valley hf", g1, 0);
    zcd = 1'b1;
    run(3);
    chk("R3 valley start base", g0, 1);
    chk("R3 valley start hf", g1, 1);

    phase = "R5";
    run(300);
    chk("R5 ceiling base", last_int[0], PB);
    chk("R5 ceiling hf", last_int[1], PH);

    phase = "R6";
    line = '0;
    run(300);
    chk("R6 low line base", last_int[0], PB + 31);
    chk("R6 low line hf", last_int[1], PH + 31);

    phase = "R4";
    line = '1; ton = 8'd40;
    run(300);
    chk("R4 blanking period base", last_int[0], 40 + ZCB + 1);
    chk("R4 blanking period hf", last_int[1], 40 + ZCB + 1);

    phase = "R7";
    ton = 8'd20;
    run(200);
    chk("R7 on-time base", hi_len[0], 20);
    chk("R7 on-time hf", hi_len[1], 20);
    @(posedge g0);
    @(negedge clk);
    ton = 8'd3;
    @(negedge g0);
    run(1);
    chk("R7 latched on-time", hi_len[0], 20);
    ton = 8'd0;
    run(200);
    chk("R7 zero on-time", hi_len[0], 1);
    chk("R7 zero on-time hf", hi_len[1], 1);

    phase = "R9";
    ton = 8'd20; cs = 1'b1;
    run(200);
    chk("R9 current cut base", hi_len[0], LEB + 1);
    chk("R9 current cut hf", hi_len[1], LEB + 1);
    chk("R8 blanking kept pulse", int'(hi_len[0] > LEB), 1);
    cs = 1'b0;

    phase = "R10";
    zcd = 1'b0; ton = 8'd10;
    run(400);
    chk("R10 forced restart base", last_int[0], 10 + WDOG + 1);
    chk("R10 forced restart hf", last_int[1], 10 + WDOG + 1);

    phase = "R11";
    zcd = 1'b1;
    run(100);
    @(negedge g0);
    run(1);
    chk("R11 done on end", d0, 1);
    run(1);
    chk("R11 done single", d0, 0);

    phase = "R2";
    ton = 8'd30;
    @(posedge g0);
    run(2);
    stby = 1'b1;
    run(1);
    chk("R2 abort gate", g0, 0);
    chk("R2 abort no done", d0, 0);
    seen = 1'b0;
    for (int i = 0; i < 50; i++) begin
      run(1);
      if (g0 || g1 || d0 || d1) seen = 1'b1;
    end
    chk("R2 held off", seen, 0);
    stby = 1'b0;
    run(100);
    chk("R2 resumes", int'(hi_len[0] == 30), 1);

    finished = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule